// File: doc/BRIEF.md
# Serial Flash Whole-Array Erase Controller

This block is the device-side command logic of a serial, page-organised flash that erases the whole array on one command. A host drives chip select, serial clock and serial data in, SPI mode 0. The block recognises a fixed four-byte erase command and arms the erase. It starts a self-timed erase when chip select is released. The erase raises one strobe per sector, and it skips every sector that is locked down or covered by write protection. The array itself is abstracted: each sector is represented by one erase-enable output. A status-read command shifts out a ready flag and the protection mask now in force.

The serial pins run at the host's pace. The system clock samples them, so each serial clock level must be held for at least two system clock cycles. SPI has no back-pressure, so the block carries no valid/ready stream. Bytes that cannot be acted on are dropped, and the host learns this by polling status. The write-protect pin and the protection and lock masks are plain level inputs. A change to them during an erase is held back until the erase has finished.

Top module: `chip_erase_ctl`

## Requirements
- R1: After reset, busy is 0, every erase-enable bit is 0 and sdo is 0.
- R2: The bytes C7h, 94h, 80h, 9Ah, each sent most significant bit first on rising serial clock edges while chip select is low, arm an erase. Busy rises on the clock edge after the one that samples chip select high.
- R3: If chip select is released before all 32 command bits have been received, no erase begins.
- R4: If any of the four command bytes differs from the expected value, no erase begins.
- R5: Bytes received after the fourth command byte and before chip select rises are ignored, and the erase still starts.
- R6: Busy stays high for exactly ERASE_CYCLES clock cycles and then clears by itself.
- R7: While busy, the erase-enable output is the bitwise complement of the effective protection mask captured at the start, held constant. While idle it is zero.
- R8: Effective protection equals lock_mask OR (wp ? prot_cfg : 0). It follows the inputs one cycle late while idle. It is frozen while busy, and any change made during the erase takes effect on the first cycle after busy clears.
- R9: While busy, a newly received erase command is ignored. It neither restarts nor extends the erase.
- R10: After the status opcode D7h, sdo shifts out the status byte most significant bit first, one bit per serial clock, advancing after each rising edge. Bit 7 is 1 when ready and 0 when busy, bits 6:5 are 0, and bits 4:0 hold the effective protection mask, sector 0 in bit 0. A fresh status byte is captured at the last rising edge of every byte.
- R11: sdo is 0 whenever chip select is high or no status read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (status) |
| wp | input | 1 | Write-protect pin, active high |
| prot_cfg | input | SECTORS | Sectors protected while wp is asserted |
| lock_mask | input | SECTORS | Sectors permanently locked |
| busy | output | 1 | Erase in progress |
| erase_en | output | SECTORS | Per-sector erase strobe |

## Verification
The hardest situation to reach is a change in protection, or a second erase command, that arrives while an erase is running. These have to land inside the busy window and still be observable from the ports. The bench uses a busy window longer than one full command frame. It starts an erase with a mixed lock and write-protect mask, then drops wp and clears prot_cfg at once. It then sends a complete second erase command and reads status twice: once mid-erase, where the old mask must still show, and once after ready, where the new mask must appear. A reference model, compared on every clock, also confirms that the busy run length did not change.

// File: rtl/chip_erase_pkg.sv
package chip_erase_pkg;

  localparam logic [7:0] OP_STATUS = 8'hD7;

  typedef enum logic [2:0] {
    DEC_IDLE,
    DEC_ERASE,
    DEC_ARMED,
    DEC_STATUS,
    DEC_DROP
  } dec_state_t;

  // expected erase command byte at position idx
  function automatic logic [7:0] erase_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    erase_byte = 8'hC7;
      2'd1:    erase_byte = 8'h94;
      2'd2:    erase_byte = 8'h80;
      default: erase_byte = 8'h9A;
    endcase
  endfunction

endpackage

// File: rtl/ce_serial_rx.sv
module ce_serial_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sclk_rise,
  output logic       cs_rise,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic       sclk_q;
  logic       cs_q;
  logic [6:0] shreg;
  logic [2:0] bcnt;

  assign sclk_rise = sclk & ~sclk_q & ~cs_n;
  assign cs_rise   = cs_n & ~cs_q;
  assign byte_done = sclk_rise && (bcnt == 3'd7);
  assign byte_val  = {shreg, sdi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      shreg  <= '0;
      bcnt   <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_n) begin
        bcnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[5:0], sdi};
        bcnt  <= bcnt + 3'd1;
      end
    end
  end

endmodule

// File: rtl/ce_cmd_dec.sv
module ce_cmd_dec
  import chip_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       byte_done,
  input  logic [7:0] byte_val,
  input  logic       busy,
  output logic       armed,
  output logic       rd_mode
);
  dec_state_t state;
  logic [1:0] idx;

  assign armed   = (state == DEC_ARMED);
  assign rd_mode = (state == DEC_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= DEC_IDLE;
      idx   <= '0;
    end else if (cs_n) begin
      state <= DEC_IDLE;
      idx   <= '0;
    end else if (byte_done) begin
      case (state)
        DEC_IDLE: begin
          if (byte_val == OP_STATUS) begin
            state <= DEC_STATUS;
          end else if (byte_val == erase_byte(2'd0) && !busy) begin
            state <= DEC_ERASE;
            idx   <= 2'd1;
          end else begin
            state <= DEC_DROP;
          end
        end
        DEC_ERASE: begin
          if (byte_val == erase_byte(idx)) begin
            if (idx == 2'd3) state <= DEC_ARMED;
            else             idx   <= idx + 2'd1;
          end else begin
            state <= DEC_DROP;
          end
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/ce_erase_timer.sv
module ce_erase_timer #(
  parameter int SECTORS      = 5,
  parameter int ERASE_CYCLES = 2000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               wp,
  input  logic [SECTORS-1:0] prot_cfg,
  input  logic [SECTORS-1:0] lock_mask,
  output logic               busy,
  output logic [SECTORS-1:0] eff_prot,
  output logic [SECTORS-1:0] erase_en
);
  localparam int CNT_W = (ERASE_CYCLES > 2) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      left     <= '0;
      eff_prot <= '0;
      erase_en <= '0;
    end else begin
      if (!busy) eff_prot <= lock_mask | (wp ? prot_cfg : '0);
      if (start && !busy) begin
        busy     <= 1'b1;
        left     <= CNT_LOAD;
        erase_en <= ~eff_prot;
      end else if (busy) begin
        if (left == '0) begin
          busy     <= 1'b0;
          erase_en <= '0;
        end else begin
          left <= left - 1'b1;
        end
      end
    end
  end

  // assertion-only busy run counter
  int run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == ERASE_CYCLES);
  p_en_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> erase_en == '0);
  p_en_skips_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (erase_en & eff_prot) == '0);
  p_en_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(erase_en));
  p_prot_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(eff_prot));
  p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/ce_status_tx.sv
module ce_status_tx #(
  parameter int SECTORS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk_rise,
  input  logic               byte_done,
  input  logic               rd_mode,
  input  logic               busy,
  input  logic [SECTORS-1:0] eff_prot,
  output logic               sdo
);
  localparam int PAD = 7 - SECTORS;

  logic [7:0] sreg;
  logic [7:0] snap;

  assign snap = {~busy, {PAD{1'b0}}, eff_prot};
  assign sdo  = rd_mode & ~cs_n & sreg[7];

  always_ff @(posedge clk) begin
    if (!rst_n)          sreg <= '0;
    else if (byte_done)  sreg <= snap;
    else if (sclk_rise)  sreg <= {sreg[6:0], 1'b0};
  end

endmodule

// File: rtl/chip_erase_ctl.sv
module chip_erase_ctl #(
  parameter int SECTORS      = 5,
  parameter int ERASE_CYCLES = 2000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  input  logic               wp,
  input  logic [SECTORS-1:0] prot_cfg,
  input  logic [SECTORS-1:0] lock_mask,
  output logic               busy,
  output logic [SECTORS-1:0] erase_en
);
  logic               sclk_rise, cs_rise, byte_done;
  logic [7:0]         byte_val;
  logic               armed, rd_mode, start;
  logic [SECTORS-1:0] eff_prot;

  assign start = cs_rise & armed;

  ce_serial_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sclk_rise(sclk_rise), .cs_rise(cs_rise),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  ce_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_done(byte_done),
    .byte_val(byte_val), .busy(busy), .armed(armed), .rd_mode(rd_mode)
  );

  ce_erase_timer #(.SECTORS(SECTORS), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .wp(wp),
    .prot_cfg(prot_cfg), .lock_mask(lock_mask),
    .busy(busy), .eff_prot(eff_prot), .erase_en(erase_en)
  );

  ce_status_tx #(.SECTORS(SECTORS)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise),
    .byte_done(byte_done), .rd_mode(rd_mode), .busy(busy),
    .eff_prot(eff_prot), .sdo(sdo)
  );

  // erase may only begin right after chip select is released
  p_start_on_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_n) && !$past(cs_n, 2));

endmodule

// File: tb/chip_erase_ctl_bench.sv
module chip_erase_ctl_bench;
  localparam int NS = 5;
  localparam int E  = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, wp = 1'b0;
  logic [NS-1:0] prot_cfg = '0, lock_mask = '0;
  logic sdo, busy;
  logic [NS-1:0] erase_en;

  always #5 clk = ~clk;

  chip_erase_ctl #(.SECTORS(NS), .ERASE_CYCLES(E)) u_chip_erase_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .wp(wp), .prot_cfg(prot_cfg), .lock_mask(lock_mask),
    .busy(busy), .erase_en(erase_en)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %0h exp %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic          m_sclk_q = 1'b0, m_cs_q = 1'b1;
  int            m_bits = 0;
  logic [7:0]    m_cur = '0;
  logic [7:0]    rx_q[$];
  logic [7:0]    stat_q[$];
  logic          m_first_busy = 1'b0;
  logic          m_busy = 1'b0;
  int            m_left = 0;
  logic [NS-1:0] m_eff = '0, m_en = '0;
  int            run = 0, last_run = 0;

  function automatic logic cmd_ok();
    return rx_q.size() >= 4 && rx_q[0] == 8'hC7 && rx_q[1] == 8'h94 &&
           rx_q[2] == 8'h80 && rx_q[3] == 8'h9A && !m_first_busy;
  endfunction

  always @(posedge clk) begin
    logic i_cs, i_sclk, i_sdi, rise, csr, go, reading;
    logic [NS-1:0] new_eff;
    i_cs = cs_n; i_sclk = sclk; i_sdi = sdi;
    if (!rst_n) begin
      m_sclk_q = 1'b0; m_cs_q = 1'b1; m_bits = 0; rx_q.delete();
      m_busy = 1'b0; m_left = 0; m_eff = '0; m_en = '0; run = 0;
    end else begin
      rise = i_sclk && !m_sclk_q && !i_cs;
      csr  = i_cs && !m_cs_q;
      go   = csr && cmd_ok() && !m_busy;
      if (rise) begin
        m_cur = {m_cur[6:0], i_sdi};
        m_bits++;
        if (m_bits % 8 == 0) begin
          if (rx_q.size() == 0) m_first_busy = m_busy;
          rx_q.push_back(m_cur);
          if (rx_q[0] == 8'hD7) stat_q.push_back({~m_busy, 2'b00, m_eff});
        end
      end
      new_eff = m_busy ? m_eff : (lock_mask | (wp ? prot_cfg : '0));
      if (go) begin
        m_busy = 1'b1; m_left = E - 1; m_en = ~m_eff;
      end else if (m_busy) begin
        if (m_left == 0) begin m_busy = 1'b0; m_en = '0; end
        else m_left--;
      end
      m_eff = new_eff;
      if (i_cs) begin m_bits = 0; rx_q.delete(); end
      m_sclk_q = i_sclk; m_cs_q = i_cs;
    end
    reading = !i_cs && rx_q.size() > 0 && rx_q[0] == 8'hD7;
    #1;
    if (rst_n) begin
      chk("R6", "busy", busy, m_busy);
      chk("R7", "erase_en", erase_en, m_en);
      if (!reading) chk("R11", "sdo idle", sdo, 0);
      if (busy) run++;
      else if (run != 0) begin last_run = run; run = 0; end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_bit(input logic b);
    sdi = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input int nbits = 8);
    for (int i = 7; i > 7 - nbits; i--) send_bit(v[i]);
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0; sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_hi();
    sclk = 1'b0; repeat (2) @(negedge clk);
    cs_n = 1'b1; stat_q.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic send_erase();
    send_byte(8'hC7); send_byte(8'h94); send_byte(8'h80); send_byte(8'h9A);
  endtask

  task automatic read_status(input int nbytes, output logic [7:0] last);
    cs_lo();
    send_byte(8'hD7);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] got;
      for (int i = 7; i >= 0; i--) begin
        repeat (2) @(negedge clk);
        got[i] = sdo;
        sclk = 1'b1; repeat (2) @(negedge clk); sclk = 1'b0;
      end
      if (stat_q.size() == 0) chk("R10", "status queue empty", 1, 0);
      else chk("R10", "status byte", got, stat_q.pop_front());
      last = got;
    end
    cs_hi();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired act 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [7:0] st;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "erase_en after reset", erase_en, 0);
    chk("R1", "sdo after reset", sdo, 0);

    // plain erase, no protection
    cs_lo(); send_erase();
    chk("R2", "busy before release", busy, 0);
    cs_hi();
    chk("R2", "busy after release", busy, 1);
    chk("R7", "all sectors enabled", erase_en, 5'h1F);
    read_status(2, st);
    chk("R10", "ready bit while busy", st[7], 0);
    wait_idle();
    chk("R6", "busy run length", last_run, E);
    read_status(1, st);
    chk("R10", "status when ready", st, 8'h80);

    // truncated commands
    cs_lo(); send_byte(8'hC7); send_byte(8'h94); send_byte(8'h80, 5); cs_hi();
    repeat (5) @(negedge clk);
    chk("R3", "no erase after 21 bits", busy, 0);
    cs_lo(); send_byte(8'hC7); send_byte(8'h94); send_byte(8'h80);
    send_byte(8'h9A, 7); cs_hi();
    repeat (5) @(negedge clk);
    chk("R3", "no erase after 31 bits", busy, 0);

    // mismatching bytes
    cs_lo(); send_byte(8'hC7); send_byte(8'h94); send_byte(8'h81);
    send_byte(8'h9A); cs_hi();
    repeat (5) @(negedge clk);
    chk("R4", "third byte wrong", busy, 0);
    cs_lo(); send_byte(8'h00); send_byte(8'h94); send_byte(8'h80);
    send_byte(8'h9A); cs_hi();
    repeat (5) @(negedge clk);
    chk("R4", "first byte wrong", busy, 0);

    // trailing bytes ignored
    cs_lo(); send_erase(); send_byte(8'hAA); send_byte(8'h55); send_byte(8'hC7, 3);
    cs_hi();
    chk("R5", "erase despite trailing bytes", busy, 1);
    wait_idle();
    chk("R5", "run length with trailing bytes", last_run, E);

    // protection masking and deferred protection change
    lock_mask = 5'b00001; prot_cfg = 5'b10100; wp = 1'b1;
    repeat (3) @(negedge clk);
    cs_lo(); send_erase(); cs_hi();
    chk("R7", "protected sectors skipped", erase_en, 5'b01010);
    wp = 1'b0; prot_cfg = 5'b00000;
    cs_lo(); send_erase(); cs_hi();
    chk("R9", "erase_en unchanged by second command", erase_en, 5'b01010);
    read_status(1, st);
    chk("R8", "old mask held while busy", st, 8'h15);
    wait_idle();
    chk("R9", "run length not extended", last_run, E);
    read_status(1, st);
    chk("R8", "new mask after erase", st, 8'h81);
    chk("R11", "sdo after release", sdo, 0);

    // protection follows inputs while idle
    wp = 1'b1; prot_cfg = 5'b01000; lock_mask = '0;
    repeat (2) @(negedge clk);
    read_status(1, st);
    chk("R8", "idle mask tracks inputs", st, 8'h88);
    cs_lo(); send_erase(); cs_hi();
    chk("R7", "erase skips sector 3", erase_en, 5'b10111);
    wait_idle();
    chk("R6", "final run length", last_run, E);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule